// File: doc/BRIEF.md
# Dual-Device IDE Shadow Register File

This block is the task-file front end of an emulated disk controller. A host bus on one side writes the command-block registers. An embedded firmware port on the other side reads what the host wrote and posts per-drive results. Two virtual drives share one set of host offsets. A host write at an offset and a host read at the same offset reach different storage. For reads, the drive-select bit of the drive/head register picks which drive's output register is returned.

Three host offsets are decoded. Offset 01h takes the feature byte on a write and returns the selected drive's error byte on a read. Offset 02h takes the sector count on a write and returns the selected drive's sector-count-out byte on a read. Offset 06h holds the drive/head byte, and its bit 4 is the drive select.

A host sector-count write seeds the input copy and both drive output copies at once. It also raises a one-cycle pulse toward firmware. Firmware has a separate write strobe for each drive's error register and each drive's sector-count-out register. When firmware and the host write the same sector-count-out register in the same cycle, firmware wins.

Top module: `ide_shadow_regs`

## Requirements
- R1: After synchronous reset, the feature, sector-count-in, drive/head, both error and both sector-count-out registers hold 00h, and `fw_sc_done` and `host_rvalid` are 0.
- R2: A host write at offset 01h loads the feature byte, which is visible on `fw_feature` after the clock edge. A host read at 01h never returns the feature byte, and the host write leaves both error registers unchanged.
- R3: A host read at offset 01h returns error register 0 when drive/head bit 4 is 0, and error register 1 when it is 1.
- R4: A host write at offset 02h loads the same byte into the sector-count-in register (`fw_sc_in`) and into both sector-count-out registers on one clock edge.
- R5: A host read at offset 02h returns sector-count-out 0 when drive/head bit 4 is 0, and sector-count-out 1 when it is 1.
- R6: Firmware strobe `fw_err_we[d]` loads `fw_wdata` into error register d, and `fw_sco_we[d]` loads it into sector-count-out register d. The other drive's register is not changed.
- R7: When a host write at 02h and `fw_sco_we[d]` fall in the same cycle, sector-count-out d takes the firmware byte. The other sector-count-out register and the sector-count-in register take the host byte.
- R8: `fw_sc_done` is high for exactly the one cycle that follows each clock edge on which a host write at 02h was accepted, and low otherwise.
- R9: `host_rdata` follows the addressed register combinationally. `host_rvalid` is high in the cycle after `host_rd` was sampled high, and low otherwise. Reads change no register.
- R10: A host write at offset 06h loads the drive/head byte, which reads back at 06h. Only bit 4 of that byte affects drive selection. Reads at other offsets return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W (3) | Host register offset |
| host_wdata | input | DATA_W (8) | Host write data |
| host_rdata | output | DATA_W (8) | Host read data, combinational |
| host_rvalid | output | 1 | Read-valid, one cycle after host_rd |
| fw_err_we | input | 2 | Firmware error-register write strobe per drive |
| fw_sco_we | input | 2 | Firmware sector-count-out write strobe per drive |
| fw_wdata | input | DATA_W (8) | Firmware write data |
| fw_feature | output | DATA_W (8) | Feature byte written by the host |
| fw_sc_in | output | DATA_W (8) | Sector-count-in byte written by the host |
| fw_sc_done | output | 1 | One-cycle pulse after a host sector-count write |

## Verification
Distinct bytes are placed in the two error registers and the two sector-count-out registers, and each aliased offset is read with the drive-select bit at 0 and at 1. This shows that the read mux follows bit 4 and that a host write and a host read at one offset reach different storage. A host sector-count write followed by reads of both drives shows that the broadcast reaches both copies. A later firmware write to one drive shows that the copies are independent. A cycle with a host sector-count write and a firmware strobe together shows which source wins for the targeted drive and which for the others. A drive/head value with every bit set except bit 4 shows that no other bit steers the selection.

// File: rtl/ide_shadow_pkg.sv
package ide_shadow_pkg;
    // Two virtual drives share the task file.
    localparam int NUM_DEV = 2;
    localparam int DEV_IDX_W = 1;
    // Drive-select bit position inside the drive/head byte.
    localparam int DEV_BIT = 4;

    // Host offsets decoded by this block.
    localparam int OFS_FEAT  = 1;
    localparam int OFS_SCNT  = 2;
    localparam int OFS_DRVHD = 6;

    // Decoded host write enables.
    typedef struct packed {
        logic feat;
        logic scnt;
        logic drvhd;
    } host_we_t;

    // Which register a host read targets.
    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_ERR   = 2'd1,
        RSEL_SCO   = 2'd2,
        RSEL_DRVHD = 2'd3
    } rd_sel_e;

    function automatic rd_sel_e rd_select(input int unsigned ofs);
        case (ofs)
            OFS_FEAT:  return RSEL_ERR;
            OFS_SCNT:  return RSEL_SCO;
            OFS_DRVHD: return RSEL_DRVHD;
            default:   return RSEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/ide_host_decode.sv
module ide_host_decode
    import ide_shadow_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    output host_we_t          we
);
    always_comb begin
        we.feat  = host_wr && (host_addr == ADDR_W'(OFS_FEAT));
        we.scnt  = host_wr && (host_addr == ADDR_W'(OFS_SCNT));
        we.drvhd = host_wr && (host_addr == ADDR_W'(OFS_DRVHD));
    end
endmodule

// File: rtl/ide_dev_regs.sv
module ide_dev_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sc_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              fw_err_we,
    input  logic              fw_sco_we,
    input  logic [DATA_W-1:0] fw_wdata,
    output logic [DATA_W-1:0] err_q,
    output logic [DATA_W-1:0] sco_q
);
    // Error byte: firmware only.
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= '0;
        else if (fw_err_we)
            err_q <= fw_wdata;
    end

    // Sector-count-out: firmware write has priority over the host broadcast.
    always_ff @(posedge clk) begin
        if (rst)
            sco_q <= '0;
        else if (fw_sco_we)
            sco_q <= fw_wdata;
        else if (host_sc_we)
            sco_q <= host_wdata;
    end
endmodule

// File: rtl/ide_read_mux.sv
module ide_read_mux
    import ide_shadow_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]              host_addr,
    input  logic [DATA_W-1:0]              drvhd_q,
    input  logic [NUM_DEV-1:0][DATA_W-1:0] err_q,
    input  logic [NUM_DEV-1:0][DATA_W-1:0] sco_q,
    output logic [DATA_W-1:0]              rdata
);
    logic [DEV_IDX_W-1:0] dev;
    rd_sel_e              sel;

    always_comb begin
        dev = drvhd_q[DEV_BIT];
        sel = rd_select(int'(host_addr));
        case (sel)
            RSEL_ERR:   rdata = err_q[dev];
            RSEL_SCO:   rdata = sco_q[dev];
            RSEL_DRVHD: rdata = drvhd_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ide_shadow_regs.sv
module ide_shadow_regs
    import ide_shadow_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_rvalid,
    input  logic [NUM_DEV-1:0] fw_err_we,
    input  logic [NUM_DEV-1:0] fw_sco_we,
    input  logic [DATA_W-1:0]  fw_wdata,
    output logic [DATA_W-1:0]  fw_feature,
    output logic [DATA_W-1:0]  fw_sc_in,
    output logic               fw_sc_done
);
    host_we_t                     we;
    logic [DATA_W-1:0]            drvhd_q;
    logic [NUM_DEV-1:0][DATA_W-1:0] err_q;
    logic [NUM_DEV-1:0][DATA_W-1:0] sco_q;

    ide_host_decode #(.ADDR_W(ADDR_W)) u_dec (
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .we        (we)
    );

    // Host-owned command-block registers and handshake flops.
    always_ff @(posedge clk) begin
        if (rst) begin
            fw_feature  <= '0;
            fw_sc_in    <= '0;
            drvhd_q     <= '0;
            fw_sc_done  <= 1'b0;
            host_rvalid <= 1'b0;
        end else begin
            if (we.feat)  fw_feature <= host_wdata;
            if (we.scnt)  fw_sc_in   <= host_wdata;
            if (we.drvhd) drvhd_q    <= host_wdata;
            fw_sc_done  <= we.scnt;
            host_rvalid <= host_rd;
        end
    end

    // One output register set per virtual drive.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        ide_dev_regs #(.DATA_W(DATA_W)) u_dev (
            .clk        (clk),
            .rst        (rst),
            .host_sc_we (we.scnt),
            .host_wdata (host_wdata),
            .fw_err_we  (fw_err_we[d]),
            .fw_sco_we  (fw_sco_we[d]),
            .fw_wdata   (fw_wdata),
            .err_q      (err_q[d]),
            .sco_q      (sco_q[d])
        );
    end

    ide_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rmux (
        .host_addr (host_addr),
        .drvhd_q   (drvhd_q),
        .err_q     (err_q),
        .sco_q     (sco_q),
        .rdata     (host_rdata)
    );
endmodule

// File: rtl/ide_shadow_chk.sv
module ide_shadow_chk
    import ide_shadow_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         host_wr,
    input logic                         host_rd,
    input logic [ADDR_W-1:0]            host_addr,
    input logic [DATA_W-1:0]            host_wdata,
    input logic                         host_rvalid,
    input logic [NUM_DEV-1:0]           fw_err_we,
    input logic [NUM_DEV-1:0]           fw_sco_we,
    input logic [DATA_W-1:0]            fw_wdata,
    input logic [DATA_W-1:0]            fw_feature,
    input logic [DATA_W-1:0]            fw_sc_in,
    input logic                         fw_sc_done,
    input logic [NUM_DEV-1:0][DATA_W-1:0] err_q,
    input logic [NUM_DEV-1:0][DATA_W-1:0] sco_q
);
    logic hsc;
    assign hsc = host_wr && (host_addr == ADDR_W'(OFS_SCNT));

    // R2
    feature_load_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_W'(OFS_FEAT)) |=> fw_feature == $past(host_wdata));

    // R4
    scnt_broadcast_chk: assert property (@(posedge clk) disable iff (rst)
        (hsc && fw_sco_we == '0) |=> (fw_sc_in == $past(host_wdata))
            && (sco_q[0] == $past(host_wdata)) && (sco_q[1] == $past(host_wdata)));

    // R6
    err0_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fw_err_we[0] |=> $stable(err_q[0]));

    // R7
    fw_wins_chk: assert property (@(posedge clk) disable iff (rst)
        fw_sco_we[1] |=> sco_q[1] == $past(fw_wdata));

    // R8
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        hsc |=> fw_sc_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !hsc |=> !fw_sc_done);

    // R9
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    // R9
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !host_rvalid);
endmodule

bind ide_shadow_regs ide_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_ide_shadow_regs.sv
module test_ide_shadow_regs;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr, host_rd;
    logic [2:0] host_addr;
    logic [7:0] host_wdata, host_rdata;
    logic       host_rvalid;
    logic [1:0] fw_err_we, fw_sco_we;
    logic [7:0] fw_wdata, fw_feature, fw_sc_in;
    logic       fw_sc_done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    ide_shadow_regs i_ide_shadow_regs (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .fw_err_we(fw_err_we), .fw_sco_we(fw_sco_we), .fw_wdata(fw_wdata),
        .fw_feature(fw_feature), .fw_sc_in(fw_sc_in), .fw_sc_done(fw_sc_done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Host write: driven at negedge, taken at the next posedge, returns at the following negedge.
    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic fw_write(input logic err, input int dev, input logic [7:0] d);
        @(negedge clk);
        fw_wdata = d;
        if (err) fw_err_we[dev] = 1'b1; else fw_sco_we[dev] = 1'b1;
        @(negedge clk);
        fw_err_we = '0; fw_sco_we = '0;
    endtask

    // Combinational read without a strobe.
    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 feature", fw_feature, 8'h00);
        check("R1 sc_in", fw_sc_in, 8'h00);
        check("R1 done", {7'd0, fw_sc_done}, 8'h00);
        check("R1 rvalid", {7'd0, host_rvalid}, 8'h00);
        peek(3'd1, v); check("R1 err read", v, 8'h00);
        peek(3'd2, v); check("R1 sco read", v, 8'h00);
        peek(3'd6, v); check("R1 drvhd read", v, 8'h00);
    endtask

    task automatic t_feature;
        logic [7:0] v;
        host_write(3'd1, 8'hA5);
        check("R2 fw_feature", fw_feature, 8'hA5);
        peek(3'd1, v); check("R2 read 01h is error not feature", v, 8'h00);
    endtask

    task automatic t_error_select;
        logic [7:0] v;
        fw_write(1'b1, 0, 8'h11);
        fw_write(1'b1, 1, 8'h22);
        peek(3'd1, v); check("R3 R6 err dev0", v, 8'h11);
        host_write(3'd6, 8'h10);
        peek(3'd6, v); check("R10 drvhd readback", v, 8'h10);
        peek(3'd1, v); check("R3 R6 err dev1", v, 8'h22);
        host_write(3'd1, 8'h5A);
        peek(3'd1, v); check("R2 err1 unchanged by host", v, 8'h22);
    endtask

    task automatic t_sector;
        logic [7:0] v;
        host_write(3'd2, 8'h3C);
        check("R8 done high", {7'd0, fw_sc_done}, 8'h01);
        check("R4 sc_in", fw_sc_in, 8'h3C);
        @(negedge clk);
        check("R8 done one cycle", {7'd0, fw_sc_done}, 8'h00);
        peek(3'd2, v); check("R4 R5 sco dev1", v, 8'h3C);
        host_write(3'd6, 8'h00);
        peek(3'd2, v); check("R4 R5 sco dev0", v, 8'h3C);
    endtask

    task automatic t_fw_sco;
        logic [7:0] v;
        fw_write(1'b0, 1, 8'h77);
        peek(3'd2, v); check("R6 sco dev0 untouched", v, 8'h3C);
        host_write(3'd6, 8'h10);
        peek(3'd2, v); check("R5 R6 sco dev1", v, 8'h77);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'd2; host_wdata = 8'h99;
        fw_sco_we = 2'b01; fw_wdata = 8'h55;
        @(negedge clk);
        host_wr = 1'b0; fw_sco_we = '0;
        check("R7 sc_in host", fw_sc_in, 8'h99);
        peek(3'd2, v); check("R7 dev1 host value", v, 8'h99);
        host_write(3'd6, 8'hEF);
        peek(3'd2, v); check("R7 R10 dev0 firmware wins, bit4 only", v, 8'h55);
        peek(3'd5, v); check("R10 unmapped offset", v, 8'h00);
    endtask

    task automatic t_rvalid;
        logic [7:0] v;
        @(negedge clk);
        host_rd = 1'b1; host_addr = 3'd2;
        #1 v = host_rdata;
        check("R9 comb data", v, 8'h55);
        @(negedge clk);
        host_rd = 1'b0;
        check("R9 rvalid high", {7'd0, host_rvalid}, 8'h01);
        @(negedge clk);
        check("R9 rvalid low", {7'd0, host_rvalid}, 8'h00);
        check("R9 no side effect", host_rdata, 8'h55);
        check("R8 no done on read", {7'd0, fw_sc_done}, 8'h00);
    endtask

    initial begin
        rst = 1'b1; host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
        fw_err_we = '0; fw_sco_we = '0; fw_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_feature();
        t_error_select();
        t_sector();
        t_fw_sco();
        t_collide();
        t_rvalid();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule